// File: doc/BRIEF.md
# Programmable Burst Column Sequencer

This block sits between a memory controller's command decoder and the column path of a two-bank synchronous DRAM. It keeps a small mode register, loaded from a key placed on the address bus together with a load-mode command. On every read or write command it walks through the column addresses of the burst, one per clock, and it raises a read-data-valid strobe once for each read beat, delayed by the programmed CAS latency.

The burst order is either a linear count or an XOR pattern. Both orders stay inside the naturally aligned block of the burst length. A full-page setting steps through all 256 columns of a row and wraps around until a stop command arrives. Writes always move a single word. A fresh read or write command replaces a burst that is still running.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `burst_act_o` and `rd_valid_o` are low, and the mode is burst length 1, sequential order, CAS latency 3.
- R2: Command codes on `cmd_i` are 0 idle, 1 load mode, 2 read, 3 write, 4 burst stop; codes 5 to 7 act as idle. A load-mode command takes its key from `addr_i[6:0]`. Bits [2:0] select the burst length (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page). Bit 3 selects the order (0 sequential, 1 interleaved). Bits [6:4] select the CAS latency (2 or 3).
- R3: A key with a length code of 4, 5 or 6, or with a latency code other than 2 or 3, is dropped as a whole, and the previous mode stays in force.
- R4: On the cycle after a read or write command is sampled, `col_o` equals `addr_i[7:0]` from that command, `bank_o` equals the sampled `bank_i`, and `burst_act_o` stays high for exactly the burst length in cycles.
- R5: In sequential order, beat k presents the start column with its low log2(BL) bits replaced by (start + k) mod BL.
- R6: In interleaved order, beat k presents the start column with its low log2(BL) bits replaced by start XOR k.
- R7: A full-page read counts up through the columns modulo 256 in sequential order, whatever the order bit says. It runs until a burst-stop or a new command, and `burst_act_o` is low on the cycle after a sampled burst-stop.
- R8: A write presents one column for one cycle, whatever the burst length, and produces no `rd_valid_o`.
- R9: A read or write command that arrives during a burst ends that burst and starts a new sequence from the new start column.
- R10: `rd_valid_o` is high exactly CL cycles after each cycle in which a read beat is presented, and at no other time.
- R11: A load-mode command is ignored while a burst is active or read-valid strobes are still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command code |
| addr_i | input | 11 | Start column in [7:0] for reads and writes; mode key in [6:0] for load-mode |
| bank_i | input | 1 | Bank select for a read or write |
| col_o | output | 8 | Column of the current beat |
| bank_o | output | 1 | Bank of the current burst |
| burst_act_o | output | 1 | High while a beat is being presented |
| rd_valid_o | output | 1 | Read data valid, delayed by the CAS latency |

## Verification
The assertions watch on every cycle that a command shows its start column and bank on the next cycle, that a stop command clears the active flag, and that a write lasts one beat. They also check that a full-page burst steps by one column, that read-valid follows read beats by exactly the current latency, and that the mode does not change while the block is busy. The bench scenarios are the only way to show the full column order of each burst length in both orders, the rejection of bad keys, the default mode after reset, the full-page wrap past column 255, and the exact count of valid strobes when one read cuts off another.

// File: rtl/bcs_pkg.sv
// Package bcs_pkg: command codes, burst-length codes and the mode record
// shared by the burst column sequencer and its checker.
package bcs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_LMR = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4
    } cmd_t;

    typedef enum logic [2:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_FULL = 3'd7
    } bl_t;

    typedef struct packed {
        bl_t        bl;
        logic       ilv;
        logic [1:0] cl;
    } mode_t;

    localparam int unsigned MAX_CL = 3;
    localparam int unsigned KEY_W  = 7;

    // True when a length code names a supported burst length.
    function automatic logic bl_code_ok(input logic [2:0] code);
        return (code <= 3'd3) || (code == 3'd7);
    endfunction

    // True when a latency code names a supported CAS latency.
    function automatic logic cl_code_ok(input logic [2:0] code);
        return (code == 3'd2) || (code == 3'd3);
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
// Module bcs_mode_reg: holds the burst length, order and CAS latency.
// Loads a new key only on a load-mode command while the sequencer is idle
// and only when every field of the key is supported.
// Assumes ADDR_W >= 7 so the full key is present on the address bus.
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] key,
    input  logic              busy,
    output mode_t             mode_o
);

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       key_ok;
    logic       take;
    mode_t      mode_q;

    // Split the key into its fields and judge whether it is acceptable.
    always_comb begin
        len_code = key[2:0];
        lat_code = key[6:4];
        key_ok   = bl_code_ok(len_code) && cl_code_ok(lat_code);
        take     = (cmd == CMD_LMR) && !busy && key_ok;
    end

    // Mode register with reset default of length 1, sequential, latency 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.bl  <= BL_1;
            mode_q.ilv <= 1'b0;
            mode_q.cl  <= 2'd3;
        end else if (take) begin
            mode_q.bl  <= bl_t'(len_code);
            mode_q.ilv <= key[3];
            mode_q.cl  <= lat_code[1:0];
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/bcs_col_gen.sv
// Module bcs_col_gen: runs one burst at a time and forms the column of each
// beat. The burst shape is frozen at the command so a later mode change
// cannot disturb it. Writes are single beats; full page is always linear.
// Assumes COL_W >= 3 so a burst of 8 fits in the column field.
module bcs_col_gen
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic [COL_W-1:0] start_col,
    input  logic             bank_in,
    input  mode_t            mode,
    output logic [COL_W-1:0] col_o,
    output logic             bank_o,
    output logic             act_o,
    output logic             rd_o,
    output logic             fp_o
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             fp_q;
    logic             rd_q;
    logic             act_q;
    logic             bank_q;
    logic [COL_W-1:0] mode_mask;
    logic             start;
    logic             last_beat;

    // Translate the programmed length into a mask over the wrapping bits.
    always_comb begin
        unique case (mode.bl)
            BL_1:    mode_mask = '0;
            BL_2:    mode_mask = COL_W'(1);
            BL_4:    mode_mask = COL_W'(3);
            BL_8:    mode_mask = COL_W'(7);
            default: mode_mask = ALL_ONES;
        endcase
        start     = (cmd == CMD_RD) || (cmd == CMD_WR);
        last_beat = !fp_q && (beat_q == mask_q);
    end

    // Burst state: start, step, natural end, or stop command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            fp_q   <= 1'b0;
            rd_q   <= 1'b0;
            act_q  <= 1'b0;
            bank_q <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            beat_q <= '0;
            act_q  <= 1'b1;
            bank_q <= bank_in;
            rd_q   <= (cmd == CMD_RD);
            if (cmd == CMD_WR) begin
                mask_q <= '0;
                fp_q   <= 1'b0;
                ilv_q  <= 1'b0;
            end else begin
                mask_q <= mode_mask;
                fp_q   <= (mode.bl == BL_FULL);
                ilv_q  <= mode.ilv && (mode.bl != BL_FULL);
            end
        end else if (cmd == CMD_BST) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            if (last_beat) begin
                act_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Column of the current beat: fixed high bits, ordered low bits.
    always_comb begin
        if (ilv_q) begin
            col_o = (base_q & ~mask_q) | ((base_q ^ beat_q) & mask_q);
        end else begin
            col_o = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
        end
    end

    assign bank_o = bank_q;
    assign act_o  = act_q;
    assign rd_o   = rd_q;
    assign fp_o   = fp_q;

endmodule

// File: rtl/bcs_rd_pipe.sv
// Module bcs_rd_pipe: delays the read-beat flag by the CAS latency and
// reports whether any strobe is still in flight.
// Assumes the latency only changes while the pipe is empty.
module bcs_rd_pipe #(
    parameter int unsigned DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_in,
    input  logic [1:0] cl,
    output logic       valid_o,
    output logic       pending_o
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] stage_q;
    logic [IDX_W-1:0] tap;

    // Shift the read-beat flag one stage per clock.
    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= beat_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[DEPTH-2:0], beat_in};
            end
        end
    endgenerate

    // Pick the stage that matches the programmed latency.
    always_comb begin
        tap       = IDX_W'(cl - 2'd1);
        valid_o   = stage_q[tap];
        pending_o = |stage_q;
    end

endmodule

// File: rtl/burst_col_seq.sv
// Module burst_col_seq: top of the burst column sequencer. Decodes the
// command, holds the mode, generates burst columns and delays the read
// strobe by the CAS latency. Assumes one command per clock.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bank_i,
    output logic [COL_W-1:0]  col_o,
    output logic              bank_o,
    output logic              burst_act_o,
    output logic              rd_valid_o
);

    cmd_t  cmd;
    mode_t mode_q;
    logic  gen_rd;
    logic  gen_fp;
    logic  rd_pending;
    logic  busy;
    logic  rd_beat;

    // Map the raw code to a command; unused codes act as idle.
    always_comb begin
        unique case (cmd_i)
            3'd1:    cmd = CMD_LMR;
            3'd2:    cmd = CMD_RD;
            3'd3:    cmd = CMD_WR;
            3'd4:    cmd = CMD_BST;
            default: cmd = CMD_NOP;
        endcase
    end

    bcs_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .key    (addr_i),
        .busy   (busy),
        .mode_o (mode_q)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .start_col (addr_i[COL_W-1:0]),
        .bank_in   (bank_i),
        .mode      (mode_q),
        .col_o     (col_o),
        .bank_o    (bank_o),
        .act_o     (burst_act_o),
        .rd_o      (gen_rd),
        .fp_o      (gen_fp)
    );

    // A read beat is any active cycle of a read burst.
    assign rd_beat = burst_act_o && gen_rd;

    bcs_rd_pipe #(.DEPTH(MAX_CL)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_in   (rd_beat),
        .cl        (mode_q.cl),
        .valid_o   (rd_valid_o),
        .pending_o (rd_pending)
    );

    // The block is busy while a burst runs or strobes are in flight.
    assign busy = burst_act_o || rd_pending;

endmodule

// File: rtl/bcs_checker.sv
// Module bcs_checker: cycle-level properties of the burst column sequencer,
// attached to every instance of the top module by the bind below.
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              bank_i,
    input logic [COL_W-1:0]  col_o,
    input logic              bank_o,
    input logic              burst_act_o,
    input logic              rd_valid_o,
    input logic              rd_flag,
    input logic              fp_flag,
    input mode_t             mode,
    input logic              busy
);

    logic is_start;
    logic rbeat;
    assign is_start = (cmd_i == 3'd2) || (cmd_i == 3'd3);
    assign rbeat    = burst_act_o && rd_flag;

    AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
        is_start |=> burst_act_o && (col_o == $past(addr_i[COL_W-1:0])) && (bank_o == $past(bank_i))); // R4

    AST_CUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (is_start && burst_act_o) |=> (col_o == $past(addr_i[COL_W-1:0]))); // R9

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4) |=> !burst_act_o); // R7

    AST_FP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act_o && fp_flag && (cmd_i == 3'd0)) |=> burst_act_o && (col_o == $past(col_o) + 1'b1)); // R7

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act_o && !rd_flag && !is_start) |=> !burst_act_o); // R8

    AST_RDV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o == ((mode.cl == 2'd3) ? $past(rbeat, 3) : $past(rbeat, 2))); // R10

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode)); // R11

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_bcs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .bank_i      (bank_i),
    .col_o       (col_o),
    .bank_o      (bank_o),
    .burst_act_o (burst_act_o),
    .rd_valid_o  (rd_valid_o),
    .rd_flag     (gen_rd),
    .fp_flag     (gen_fp),
    .mode        (mode_q),
    .busy        (busy)
);

// File: tb/tb_burst_col_seq.sv
// Bench for burst_col_seq: a vector table walked by one loop, then directed
// tests for reset, rejected keys, busy mode loads and cut-off bursts.
module tb_burst_col_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = 3'd0;
    logic [10:0] addr_i = '0;
    logic        bank_i = 1'b0;
    logic [7:0]  col_o;
    logic        bank_o;
    logic        burst_act_o;
    logic        rd_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_i),
        .addr_i      (addr_i),
        .bank_i      (bank_i),
        .col_o       (col_o),
        .bank_o      (bank_o),
        .burst_act_o (burst_act_o),
        .rd_valid_o  (rd_valid_o)
    );

    // Packed vector: key[31:25] rd[24] col[23:16] bank[15] beats[14:6]
    // fullpage[5] interleave[4] cl[3:2]
    localparam int NVEC = 10;
    localparam logic [31:0] VEC [NVEC] = '{
        {7'h30, 1'b1, 8'h15, 1'b0, 9'd1,   1'b0, 1'b0, 2'd3, 2'd0},
        {7'h31, 1'b1, 8'h0B, 1'b1, 9'd2,   1'b0, 1'b0, 2'd3, 2'd0},
        {7'h22, 1'b1, 8'h2E, 1'b0, 9'd4,   1'b0, 1'b0, 2'd2, 2'd0},
        {7'h2A, 1'b1, 8'h2D, 1'b1, 9'd4,   1'b0, 1'b1, 2'd2, 2'd0},
        {7'h33, 1'b1, 8'h75, 1'b1, 9'd8,   1'b0, 1'b0, 2'd3, 2'd0},
        {7'h3B, 1'b1, 8'h75, 1'b0, 9'd8,   1'b0, 1'b1, 2'd3, 2'd0},
        {7'h23, 1'b0, 8'h40, 1'b1, 9'd1,   1'b0, 1'b0, 2'd2, 2'd0},
        {7'h37, 1'b1, 8'hFC, 1'b0, 9'd260, 1'b1, 1'b0, 2'd3, 2'd0},
        {7'h2F, 1'b1, 8'h10, 1'b1, 9'd20,  1'b1, 1'b0, 2'd2, 2'd0},
        {7'h22, 1'b0, 8'h33, 1'b0, 9'd1,   1'b0, 1'b0, 2'd2, 2'd0}
    };

    task automatic chk(input string rq, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", rq, got, exp);
        end
    endtask

    task automatic load_mode(input logic [6:0] key);
        @(negedge clk);
        cmd_i  = 3'd1;
        addr_i = {4'd0, key};
        @(negedge clk);
        cmd_i  = 3'd0;
    endtask

    // Issue one burst and check every beat and every read strobe.
    task automatic run_burst(input bit rd, input logic [7:0] col, input bit bank,
                             input int nb, input bit fp, input bit ilv, input int cl);
        int mask;
        mask = fp ? 255 : nb - 1;
        @(negedge clk);
        cmd_i  = rd ? 3'd2 : 3'd3;
        addr_i = {3'd0, col};
        bank_i = bank;
        for (int j = 0; j < nb + cl + 2; j++) begin
            int ecol;
            @(negedge clk);
            cmd_i = 3'd0;
            if (ilv) ecol = (col & ~mask & 255) | ((col ^ j) & mask);
            else     ecol = (col & ~mask & 255) | ((col + j) & mask);
            chk("R4 active", burst_act_o, j < nb);
            if (j == 0) chk("R4 bank", bank_o, bank);
            if (j < nb) chk(fp ? "R7 col" : (ilv ? "R6 col" : "R5 col"), col_o, ecol);
            if (rd) chk("R10 rd_valid", rd_valid_o, (j >= cl) && (j - cl < nb));
            else    chk("R8 rd_valid", rd_valid_o, 0);
            if (fp && j == nb - 1) cmd_i = 3'd4;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active", burst_act_o, 0);
        chk("R1 rd_valid", rd_valid_o, 0);
        // R1: default mode is length 1, sequential, latency 3
        run_burst(1'b1, 8'h9A, 1'b1, 1, 1'b0, 1'b0, 3);

        // R2: each vector loads a key, then runs its burst
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] w;
            w = VEC[v];
            load_mode(w[31:25]);
            run_burst(w[24], w[23:16], w[15], int'(w[14:6]), w[5], w[4], int'(w[3:2]));
        end

        // R3: unsupported length or latency codes leave the mode unchanged
        load_mode(7'h32);
        load_mode(7'h34);
        load_mode(7'h52);
        load_mode(7'h06);
        run_burst(1'b1, 8'h61, 1'b0, 4, 1'b0, 1'b0, 3);

        // R11: a key during a burst is ignored
        load_mode(7'h23);
        @(negedge clk);
        cmd_i  = 3'd2;
        addr_i = 11'h010;
        @(negedge clk);
        cmd_i  = 3'd1;
        addr_i = 11'h030;
        @(negedge clk);
        cmd_i  = 3'd0;
        repeat (14) @(negedge clk);
        run_burst(1'b1, 8'h20, 1'b1, 8, 1'b0, 1'b0, 2);

        // R9: a second read cuts the first after two beats
        begin
            int vcount;
            vcount = 0;
            @(negedge clk);
            cmd_i  = 3'd2;
            addr_i = 11'h050;
            bank_i = 1'b0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                cmd_i = 3'd0;
                if (rd_valid_o) vcount++;
                if (k == 0)  chk("R9 first col", col_o, 8'h50);
                if (k == 1)  chk("R9 second col", col_o, 8'h51);
                if (k == 2)  chk("R9 restart col", col_o, 8'h88);
                if (k == 2)  chk("R9 restart bank", bank_o, 1);
                if (k == 3)  chk("R9 next col", col_o, 8'h89);
                if (k == 9)  chk("R9 last col", col_o, 8'h8F);
                if (k == 10) chk("R9 end", burst_act_o, 0);
                if (k == 1) begin
                    cmd_i  = 3'd2;
                    addr_i = 11'h088;
                    bank_i = 1'b1;
                end
            end
            chk("R10 strobe count", vcount, 10);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule